// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Direct Routing

This block gathers 32 level-sensitive interrupt request lines from peripherals and presents them to a primary interrupt controller over a 32-line upstream vector. Each clock it captures the request levels into a raw-level register. An enable mask selects which captured levels count. Any enabled and active request raises the aggregate line, which is the top upstream line (index 31).

A second mask, the routing mask, may be set only for lines 21 through 30. A line whose routing bit is set also drives the upstream line with the same index. This path runs alongside the aggregate line, so the primary controller can give that source its own vector. Every other upstream line is held low.

Software reaches the block through a simple synchronous register port with a 4 KiB byte window. The register is chosen by the byte address divided by four. Both masks change only through set and clear words, so no write has to read the old value first. All outputs come from registers.

Top module: `irqfan_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the raw levels, the enable mask and the routing mask. It also drives the upstream vector and the read data to zero.
- R2: A read of word 1 (byte offset 0x004) returns the captured raw levels. A read of word 0 (offset 0x000) returns the raw levels ANDed with the enable mask.
- R3: A write to word 2 (offset 0x008) ORs the write data into the enable mask. A read of word 2 returns the enable mask.
- R4: A write to word 3 (offset 0x00C) clears each enable bit where the write data holds a one. All other enable bits are kept.
- R5: Upstream line 31 is high exactly when the AND of the raw levels and the enable mask is nonzero.
- R6: A write of any nonzero value to word 4 (offset 0x010) sets enable bit 0. A nonzero write to word 5 (offset 0x014) clears enable bit 0. A zero write to either word changes nothing. A read of word 4 returns raw level bit 0 in bit 0, with all other bits zero.
- R7: A write to word 8 (offset 0x020) ORs the write data ANDed with 0x7FE00000 into the routing mask, so only bits 21 to 30 can be set. A read of word 8 returns the routing mask.
- R8: A write to word 9 (offset 0x024) clears each routing bit where the write data holds a one.
- R9: Each upstream line from 21 to 30 equals the raw level of the same index while its routing bit is set, and is low while it is clear. Upstream lines 0 to 20 are always low.
- R10: Reads of any word other than 0, 1, 2, 4 and 8 return zero. Writes to any word other than 2, 3, 4, 5, 8 and 9 leave all state unchanged. Byte address bits 1:0 are ignored.
- R11: Read data appears on the cycle after the read request. On any cycle after a cycle without a read, the read data is zero.
- R12: The upstream vector shows a change of the request inputs or a register write on the first clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 32 | Level-sensitive request inputs |
| up_irq | output | 32 | Upstream lines: 31 is the aggregate, 21 to 30 are routable |

## Verification
The upstream vector is due one edge after the stimulus: a request change or a mask write made in one cycle shows in the next cycle. Read data is also due one edge after the request. It reflects the state from before that edge, so a read issued in the same cycle as a request change returns the old levels. The bench drives each stimulus at a falling edge and lets one rising edge pass. It then compares the outputs at the next falling edge with a model that applies the same order: read from the old state, then update the state, then route from the new state. This ordering is exercised by directed cases and by random sequences that mix mapped and unmapped words.

// File: rtl/irqfan_pkg.sv
package irqfan_pkg;

    localparam int IRQ_N     = 32;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int WORD_W    = ADDR_W - 2;
    localparam int PT_LO_DEF = 21;
    localparam int PT_HI_DEF = 30;
    localparam int AGG_DEF   = 31;

    typedef logic [IRQ_N-1:0]  irq_vec_t;
    typedef logic [DATA_W-1:0] data_t;

    // register word index (byte address / 4)
    typedef enum logic [WORD_W-1:0] {
        W_MSTAT   = 10'd0,
        W_RAW     = 10'd1,
        W_ENSET   = 10'd2,
        W_ENCLR   = 10'd3,
        W_SOFTSET = 10'd4,
        W_SOFTCLR = 10'd5,
        W_RTSET   = 10'd8,
        W_RTCLR   = 10'd9
    } word_e;

    typedef struct packed {
        logic  rd;
        logic  wr;
        logic  wr_hit;
        word_e word;
        data_t data;
    } bus_req_t;

    typedef struct packed {
        irq_vec_t raw;
        irq_vec_t en;
        irq_vec_t route;
    } ctl_state_t;

    function automatic irq_vec_t span_mask(input int lo, input int hi);
        irq_vec_t m;
        m = '0;
        for (int i = 0; i < IRQ_N; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic is_write_word(input word_e w);
        return (w == W_ENSET) || (w == W_ENCLR) || (w == W_SOFTSET) ||
               (w == W_SOFTCLR) || (w == W_RTSET) || (w == W_RTCLR);
    endfunction

endpackage

// File: rtl/irqfan_decode.sv
module irqfan_decode
    import irqfan_pkg::*;
(
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  data_t             wdata,
    output bus_req_t          req
);
    logic unused_lsb;
    assign unused_lsb = ^addr[1:0];

    always_comb begin
        req.rd     = sel & ~we;
        req.wr     = sel & we;
        req.word   = word_e'(addr[ADDR_W-1:2]);
        req.data   = wdata;
        req.wr_hit = sel & we & is_write_word(word_e'(addr[ADDR_W-1:2]));
    end
endmodule

// File: rtl/irqfan_regs.sv
module irqfan_regs
    import irqfan_pkg::*;
#(
    parameter int PT_LO = PT_LO_DEF,
    parameter int PT_HI = PT_HI_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_req_t   req,
    input  irq_vec_t   irq_in,
    output ctl_state_t cur,
    output ctl_state_t nxt
);
    localparam irq_vec_t RT_MASK = span_mask(PT_LO, PT_HI);

    always_comb begin
        nxt     = cur;
        nxt.raw = irq_in;
        if (req.wr) begin
            case (req.word)
                W_ENSET:   nxt.en    = cur.en | req.data;
                W_ENCLR:   nxt.en    = cur.en & ~req.data;
                W_SOFTSET: if (req.data != '0) nxt.en[0] = 1'b1;
                W_SOFTCLR: if (req.data != '0) nxt.en[0] = 1'b0;
                W_RTSET:   nxt.route = cur.route | (req.data & RT_MASK);
                W_RTCLR:   nxt.route = cur.route & ~req.data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    // R1: state is cleared by reset
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (cur == '0));

    // R7: routing mask never holds bits outside the routable span
    a_r7_route_span: assert property (@(posedge clk) disable iff (rst)
        (cur.route & ~RT_MASK) == '0);

    // R6: nonzero soft-set write sets enable bit 0
    a_r6_soft_set: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.word == W_SOFTSET && req.data != '0) |=> cur.en[0]);

    // R10: writes to unmapped words leave the masks alone
    a_r10_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (req.wr && !req.wr_hit) |=> ($stable(cur.en) && $stable(cur.route)));
endmodule

// File: rtl/irqfan_readmux.sv
module irqfan_readmux
    import irqfan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_req_t   req,
    input  ctl_state_t cur,
    output data_t      rdata
);
    data_t rd_val;

    always_comb begin
        rd_val = '0;
        case (req.word)
            W_MSTAT:   rd_val = cur.raw & cur.en;
            W_RAW:     rd_val = cur.raw;
            W_ENSET:   rd_val = cur.en;
            W_SOFTSET: rd_val[0] = cur.raw[0];
            W_RTSET:   rd_val = cur.route;
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (req.rd) rdata <= rd_val;
        else             rdata <= '0;
    end

    // R11: no read request means zero read data next cycle
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !req.rd |=> (rdata == '0));
endmodule

// File: rtl/irqfan_route.sv
module irqfan_route
    import irqfan_pkg::*;
#(
    parameter int PT_LO   = PT_LO_DEF,
    parameter int PT_HI   = PT_HI_DEF,
    parameter int AGG_BIT = AGG_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  ctl_state_t nxt,
    output irq_vec_t   up_q
);
    localparam irq_vec_t RT_MASK = span_mask(PT_LO, PT_HI);

    irq_vec_t up_d;
    logic     unused_route;
    assign unused_route = ^(nxt.route & ~RT_MASK);

    for (genvar g = 0; g < IRQ_N; g++) begin : g_line
        if (g == AGG_BIT) begin : g_agg
            assign up_d[g] = |(nxt.raw & nxt.en);
        end else if (g >= PT_LO && g <= PT_HI) begin : g_pass
            assign up_d[g] = nxt.route[g] & nxt.raw[g];
        end else begin : g_idle
            assign up_d[g] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) up_q <= '0;
        else     up_q <= up_d;
    end

    // R9: lines that are neither aggregate nor routable stay low
    a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
        (up_q & ~RT_MASK & ~(irq_vec_t'(1) << AGG_BIT)) == '0);
endmodule

// File: rtl/irqfan_ctrl.sv
module irqfan_ctrl
    import irqfan_pkg::*;
#(
    parameter int PT_LO   = PT_LO_DEF,
    parameter int PT_HI   = PT_HI_DEF,
    parameter int AGG_BIT = AGG_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IRQ_N-1:0]  irq_in,
    output logic [IRQ_N-1:0]  up_irq
);
    bus_req_t   req;
    ctl_state_t cur;
    ctl_state_t nxt;

    irqfan_decode u_decode (
        .sel   (bus_sel),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .req   (req)
    );

    irqfan_regs #(.PT_LO(PT_LO), .PT_HI(PT_HI)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .irq_in (irq_in),
        .cur    (cur),
        .nxt    (nxt)
    );

    irqfan_readmux u_readmux (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .cur   (cur),
        .rdata (bus_rdata)
    );

    irqfan_route #(.PT_LO(PT_LO), .PT_HI(PT_HI), .AGG_BIT(AGG_BIT)) u_route (
        .clk  (clk),
        .rst  (rst),
        .nxt  (nxt),
        .up_q (up_irq)
    );

    // R5: aggregate line agrees with the held levels and enable mask
    a_r5_aggregate: assert property (@(posedge clk) disable iff (rst)
        up_irq[AGG_BIT] == |(cur.raw & cur.en));

    // R9: each routable line tracks its level while routed
    for (genvar p = PT_LO; p <= PT_HI; p++) begin : g_chk
        a_r9_route_follow: assert property (@(posedge clk) disable iff (rst)
            up_irq[p] == (cur.route[p] & cur.raw[p]));
    end
endmodule

// File: tb/test_irqfan_ctrl.sv
module test_irqfan_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic [31:0] up_irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    logic [31:0] m_raw = '0, m_en = '0, m_rt = '0;

    always #2 clk = ~clk;

    irqfan_ctrl i_irqfan_ctrl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .up_irq(up_irq)
    );

    function automatic logic [31:0] f_read(input logic [9:0] w);
        case (w)
            10'd0:   return m_raw & m_en;
            10'd1:   return m_raw;
            10'd2:   return m_en;
            10'd4:   return {31'b0, m_raw[0]};
            10'd8:   return m_rt;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] f_route();
        logic [31:0] u;
        u = (m_rt & m_raw) & 32'h7FE0_0000;
        u[31] = |(m_raw & m_en);
        return u;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // drive at falling edge, one rising edge, compare at next falling edge
    task automatic step(input string tag, input logic [31:0] irq,
                        input logic sel, input logic we,
                        input logic [11:0] addr, input logic [31:0] data);
        logic [31:0] exp_rd;
        logic [9:0]  w;
        irq_in = irq; bus_sel = sel; bus_we = we;
        bus_addr = addr; bus_wdata = data;
        w = addr[11:2];
        exp_rd = (sel && !we) ? f_read(w) : 32'h0;
        if (sel && we) begin
            case (w)
                10'd2: m_en = m_en | data;
                10'd3: m_en = m_en & ~data;
                10'd4: if (data != 0) m_en[0] = 1'b1;
                10'd5: if (data != 0) m_en[0] = 1'b0;
                10'd8: m_rt = m_rt | (data & 32'h7FE0_0000);
                10'd9: m_rt = m_rt & ~data;
                default: ;
            endcase
        end
        m_raw = irq;
        @(posedge clk);
        @(negedge clk);
        chk(tag, "up_irq", up_irq, f_route());
        chk(tag, "rdata", bus_rdata, exp_rd);
    endtask

    task automatic rd(input string tag, input logic [11:0] a);
        step(tag, irq_in, 1'b1, 1'b0, a, 32'h0);
    endtask

    task automatic wr(input string tag, input logic [11:0] a, input logic [31:0] d);
        step(tag, irq_in, 1'b1, 1'b1, a, d);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] seed;
        seed = $urandom(32'd20240607);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "up_irq in reset", up_irq, 32'h0);
        chk("R1", "rdata in reset", bus_rdata, 32'h0);
        rst = 1'b0;
        rd("R1", 12'h004); rd("R1", 12'h008); rd("R1", 12'h020);

        // R2/R12: raw capture, one edge of latency
        step("R12", 32'h0000_00A5, 1'b0, 1'b0, 12'h0, 32'h0);
        rd("R2", 12'h004);
        chk("R2", "raw read", bus_rdata, 32'h0000_00A5);
        rd("R2", 12'h000);
        chk("R2", "masked read empty", bus_rdata, 32'h0);

        // R3/R5: enable set and aggregate
        wr("R3", 12'h008, 32'h0000_000F);
        chk("R5", "aggregate high", {31'b0, up_irq[31]}, 32'h1);
        wr("R3", 12'h008, 32'h0000_0100);
        rd("R3", 12'h008);
        chk("R3", "enable read", bus_rdata, 32'h0000_010F);
        rd("R2", 12'h000);

        // R4: enable clear
        wr("R4", 12'h00C, 32'h0000_000F);
        chk("R5", "aggregate low", {31'b0, up_irq[31]}, 32'h0);
        rd("R4", 12'h008);

        // R6: soft enable bit 0
        wr("R6", 12'h010, 32'h0);
        rd("R6", 12'h008);
        wr("R6", 12'h010, 32'h0000_0005);
        rd("R6", 12'h008);
        rd("R6", 12'h010);
        chk("R6", "word4 reads raw bit0", bus_rdata, 32'h1);
        wr("R6", 12'h014, 32'h0);
        wr("R6", 12'h014, 32'h8000_0000);
        rd("R6", 12'h008);

        // R7/R9: routing set with full write
        wr("R7", 12'h020, 32'hFFFF_FFFF);
        rd("R7", 12'h020);
        chk("R7", "route mask", bus_rdata, 32'h7FE0_0000);
        step("R9", 32'h5550_0000, 1'b0, 1'b0, 12'h0, 32'h0);
        chk("R9", "routed lines", up_irq & 32'h7FFF_FFFF, 32'h5540_0000);
        step("R9", 32'hFFFF_FFFF, 1'b0, 1'b0, 12'h0, 32'h0);

        // R8: routing clear
        wr("R8", 12'h024, 32'h0FE0_0000);
        chk("R8", "remaining routed", up_irq & 32'h7FE0_0000, 32'h7000_0000);
        rd("R8", 12'h020);

        // R10: unmapped words
        wr("R10", 12'h018, 32'hFFFF_FFFF);
        wr("R10", 12'h01C, 32'hFFFF_FFFF);
        wr("R10", 12'h028, 32'hFFFF_FFFF);
        wr("R10", 12'hFFC, 32'hFFFF_FFFF);
        rd("R10", 12'h008); rd("R10", 12'h020);
        rd("R10", 12'h00C); rd("R10", 12'h014); rd("R10", 12'h030);
        rd("R10", 12'h00B);
        chk("R10", "low bits ignored", bus_rdata, m_en);

        // R11: idle cycle clears read data
        step("R11", irq_in, 1'b0, 1'b0, 12'h004, 32'h0);
        step("R11", irq_in, 1'b1, 1'b1, 12'h004, 32'h0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] irq_r, d;
            logic [9:0]  w;
            logic [3:0]  pick;
            irq_r = ($urandom % 4 == 0) ? $urandom : irq_in;
            pick = 4'($urandom % 14);
            case (pick)
                4'd0: w = 10'd0;  4'd1: w = 10'd1;  4'd2: w = 10'd2;
                4'd3: w = 10'd3;  4'd4: w = 10'd4;  4'd5: w = 10'd5;
                4'd6: w = 10'd8;  4'd7: w = 10'd9;  4'd8: w = 10'd6;
                4'd9: w = 10'd7;  4'd10: w = 10'd10; 4'd11: w = 10'h3FF;
                default: w = 10'($urandom);
            endcase
            d = ($urandom % 5 == 0) ? 32'h0 : $urandom;
            step("R12", irq_r, ($urandom % 4) != 0, ($urandom % 2) != 0,
                 {w, 2'($urandom)}, d);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule